// File: doc/BRIEF.md
# Look-Ahead Four-Sample Averager

This block walks a fixed, built-in table of 64 unsigned 8-bit samples. For each position it sums the sample at that position and the three positions after it, one term per clock. It divides the sum by four and then presents the raw sample, its average and its position, marked by a one-cycle valid pulse. The window looks ahead, so the average at a position depends on later table entries. Near the top of the table, the entries past the last one are skipped and never fetched. The sum is still divided by four, so those averages read low.

The work runs in three phases under a small state machine: four add cycles, one divide cycle and one output cycle. A new result therefore appears every six enabled clocks. After position 63 the walk starts again at position 0. The enable input freezes the whole block while it is low. A synchronous reset returns the block to position 0 with an empty sum.

Top module: `lookahead_avg`

## Requirements
- R1: While `rst` is sampled high, every output is cleared to zero on the next edge. After `rst` falls, the first result carries position 0.
- R2: The table holds 255 at positions 56 to 63. At every other position i it holds (37*i + 11) mod 256. When `vld_o` is high, `smp_o` equals the table entry at `idx_o`.
- R3: When `vld_o` is high, `avg_o` equals the integer part of one quarter of the sum of the four entries at `idx_o` to `idx_o`+3. A window of four 255 entries (sum 1020) yields 255 with no overflow.
- R4: For positions 61, 62 and 63, only the entries up to position 63 are summed, and the sum is still divided by four. No entry beyond 63 is fetched.
- R5: Successive results carry positions that rise by one. After 63 the next result is position 0.
- R6: `vld_o` is high for exactly one cycle per result. The first result follows 6 enabled edges after reset, and each later result follows 6 enabled edges after the one before it.
- R7: Each window starts from an empty sum. The result for position 0 after a wrap equals the first result after reset.
- R8: While `en` is low, the block does not advance, `vld_o` stays low and all data outputs hold. When `en` returns high, the walk continues with the next position, and none is skipped or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low freezes the block |
| smp_o | output | 8 | Raw table sample at the reported position |
| avg_o | output | 8 | Look-ahead four-sample average for that position |
| idx_o | output | 6 | Table position of the current result |
| vld_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench goes after the table top, where positions 56 to 60 sum to the full 1020. An accumulator too narrow there would wrap and report a small average. At positions 61 to 63 the window is cut short, and a design that read past the end or divided by the shortened count would return the wrong value. The wrap from 63 to 0 is checked against the very first result, which catches any sum carried across windows. A stall mid-run and a reset mid-window expose a design that drifts, repeats a position, skips a position or pulses `vld_o` while frozen.

// File: rtl/lookahead_avg_pkg.sv
package lookahead_avg_pkg;

  parameter int N_ENTRIES = 64;
  parameter int SMP_W     = 8;
  parameter int WIN       = 4;
  parameter int HOT_FROM  = 56;

  localparam int IDX_W = $clog2(N_ENTRIES);
  localparam int K_W   = $clog2(WIN);
  localparam int SHIFT = $clog2(WIN);
  localparam int ACC_W = SMP_W + $clog2(WIN);

  typedef enum logic [1:0] {
    ST_ACC = 2'd0,
    ST_DIV = 2'd1,
    ST_OUT = 2'd2
  } la_state_e;

  // Table content: saturated top region, arithmetic pattern elsewhere.
  function automatic logic [SMP_W-1:0] la_sample(input int unsigned pos);
    int unsigned v;
    if (pos >= HOT_FROM) return '1;
    v = (pos * 37 + 11) % 256;
    return SMP_W'(v);
  endfunction

  // Division by the window width as a right shift.
  function automatic logic [SMP_W-1:0] la_avg(input logic [ACC_W-1:0] sum);
    logic [ACC_W-1:0] q;
    q = sum >> SHIFT;
    return q[SMP_W-1:0];
  endfunction

endpackage

// File: rtl/la_sample_rom.sv
module la_sample_rom
  import lookahead_avg_pkg::*;
#(
  parameter int DEPTH = N_ENTRIES,
  parameter int DW    = SMP_W,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);

  logic [DW-1:0] table_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign table_w[g] = DW'(la_sample(g));
  end

  assign data = table_w[addr];

endmodule

// File: rtl/la_ctrl.sv
module la_ctrl
  import lookahead_avg_pkg::*;
#(
  parameter int DEPTH = N_ENTRIES,
  parameter int W     = WIN,
  localparam int AW   = $clog2(DEPTH),
  localparam int KW   = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [AW-1:0] idx_q,
  output logic [AW-1:0] rom_addr,
  output logic          add_evt,
  output logic          div_evt,
  output logic          out_evt
);

  localparam logic [AW:0]   LAST_POS = (AW+1)'(DEPTH - 1);
  localparam logic [KW-1:0] LAST_K   = KW'(W - 1);
  localparam logic [AW-1:0] TOP_IDX  = AW'(DEPTH - 1);

  la_state_e   st_q;
  logic [KW-1:0] k_q;
  logic [AW:0]   reach;
  logic          in_range;

  assign reach    = {1'b0, idx_q} + {{(AW+1-KW){1'b0}}, k_q};
  assign in_range = (reach <= LAST_POS);

  // During accumulate the window position is fetched, only when in range;
  // during output the current position is fetched for the raw sample.
  assign rom_addr = (st_q == ST_ACC && in_range) ? reach[AW-1:0] : idx_q;

  assign add_evt = en && (st_q == ST_ACC) && in_range;
  assign div_evt = en && (st_q == ST_DIV);
  assign out_evt = en && (st_q == ST_OUT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_ACC;
      k_q   <= '0;
      idx_q <= '0;
    end else if (en) begin
      unique case (st_q)
        ST_ACC: begin
          if (k_q == LAST_K) begin
            k_q  <= '0;
            st_q <= ST_DIV;
          end else begin
            k_q <= k_q + 1'b1;
          end
        end
        ST_DIV: st_q <= ST_OUT;
        ST_OUT: begin
          st_q  <= ST_ACC;
          idx_q <= (idx_q == TOP_IDX) ? '0 : idx_q + 1'b1;
        end
        default: st_q <= ST_ACC;
      endcase
    end
  end

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    out_evt |=> (idx_q == AW'($past(idx_q) + 1'b1))); // R5

  AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(idx_q) && $stable(st_q) && $stable(k_q))); // R8

  AST_FETCH_RANGE: assert property (@(posedge clk) disable iff (rst)
    add_evt |-> ({1'b0, rom_addr} <= LAST_POS && rom_addr >= idx_q)); // R4

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({add_evt, div_evt, out_evt})); // R6

endmodule

// File: rtl/la_accum.sv
module la_accum
  import lookahead_avg_pkg::*;
#(
  parameter int DW  = SMP_W,
  parameter int W   = WIN,
  localparam int AC = DW + $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          add_evt,
  input  logic          div_evt,
  input  logic          out_evt,
  input  logic [DW-1:0] smp_i,
  output logic [DW-1:0] avg_q
);

  localparam logic [AC-1:0] MAX_SUM = AC'(W * ((1 << DW) - 1));

  logic [AC-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      avg_q <= '0;
    end else begin
      if (out_evt)      acc_q <= '0;
      else if (add_evt) acc_q <= acc_q + {{(AC-DW){1'b0}}, smp_i};
      if (div_evt)      avg_q <= DW'(la_avg(ACC_W'(acc_q)));
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    acc_q <= MAX_SUM); // R3

  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    out_evt |=> (acc_q == '0)); // R7

endmodule

// File: rtl/lookahead_avg.sv
module lookahead_avg
  import lookahead_avg_pkg::*;
#(
  parameter int DEPTH = N_ENTRIES,
  parameter int DW    = SMP_W,
  parameter int W     = WIN,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [DW-1:0] smp_o,
  output logic [DW-1:0] avg_o,
  output logic [AW-1:0] idx_o,
  output logic          vld_o
);

  logic [AW-1:0] idx_q;
  logic [AW-1:0] rom_addr;
  logic [DW-1:0] rom_data;
  logic [DW-1:0] avg_q;
  logic          add_evt, div_evt, out_evt;

  la_ctrl #(.DEPTH(DEPTH), .W(W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .idx_q    (idx_q),
    .rom_addr (rom_addr),
    .add_evt  (add_evt),
    .div_evt  (div_evt),
    .out_evt  (out_evt)
  );

  la_sample_rom #(.DEPTH(DEPTH), .DW(DW)) u_rom (
    .addr (rom_addr),
    .data (rom_data)
  );

  la_accum #(.DW(DW), .W(W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .add_evt (add_evt),
    .div_evt (div_evt),
    .out_evt (out_evt),
    .smp_i   (rom_data),
    .avg_q   (avg_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      smp_o <= '0;
      avg_o <= '0;
      idx_o <= '0;
    end else begin
      vld_o <= out_evt;
      if (out_evt) begin
        smp_o <= rom_data;
        avg_o <= avg_q;
        idx_o <= idx_q;
      end
    end
  end

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
    vld_o |=> !vld_o); // R6

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!vld_o && $stable(smp_o) && $stable(avg_o) && $stable(idx_o))); // R8

endmodule

// File: tb/lookahead_avg_bench.sv
module lookahead_avg_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       en;
  logic [7:0] smp_o, avg_o;
  logic [5:0] idx_o;
  logic       vld_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  lookahead_avg u_lookahead_avg (
    .clk(clk), .rst(rst), .en(en),
    .smp_o(smp_o), .avg_o(avg_o), .idx_o(idx_o), .vld_o(vld_o)
  );

  function automatic int ref_smp(input int p);
    if (p > 55) return 255;
    return (p * 37 + 11) & 255;
  endfunction

  function automatic int ref_avg(input int p);
    int s = 0;
    for (int j = 0; j < 4; j++)
      if (p + j <= 63) s += ref_smp(p + j);
    return s / 4;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Waits for the next strobe; returns the negedge count since the call.
  task automatic next_result(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
      if (gap == 1) chk(vld_o == 1'b0 || gap > 1, "R6 pulse width", int'(vld_o), 0);
    end while (!vld_o && gap < 100);
  endtask

  task automatic check_result(input int p, input int gap, input int exp_gap);
    chk(vld_o == 1'b1, "R6 strobe", int'(vld_o), 1);
    chk(gap == exp_gap, "R6 cadence", gap, exp_gap);
    chk(int'(idx_o) == p, "R5 position", int'(idx_o), p);
    chk(int'(smp_o) == ref_smp(p), "R2 sample", int'(smp_o), ref_smp(p));
    if (p > 60)
      chk(int'(avg_o) == ref_avg(p), "R4 truncated average", int'(avg_o), ref_avg(p));
    else
      chk(int'(avg_o) == ref_avg(p), "R3 average", int'(avg_o), ref_avg(p));
  endtask

  task automatic t_reset;
    int g;
    rst = 1'b1; en = 1'b0;
    repeat (3) @(negedge clk);
    chk(vld_o == 0 && smp_o == 0 && avg_o == 0 && idx_o == 0,
        "R1 reset outputs", int'({smp_o, avg_o}), 0);
    rst = 1'b0; en = 1'b1;
    for (int c = 1; c <= 5; c++) begin
      @(negedge clk);
      chk(vld_o == 1'b0, "R6 no early strobe", int'(vld_o), 0);
    end
    @(negedge clk);
    g = 6;
    chk(int'(idx_o) == 0, "R1 first position", int'(idx_o), 0);
    check_result(0, g, 6);
  endtask

  task automatic t_stall(input int p);
    logic [7:0] s0, a0;
    logic [5:0] i0;
    s0 = smp_o; a0 = avg_o; i0 = idx_o;
    en = 1'b0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      chk(vld_o == 1'b0, "R8 no strobe while frozen", int'(vld_o), 0);
      chk(smp_o == s0 && avg_o == a0 && idx_o == i0, "R8 outputs hold", int'(idx_o), int'(i0));
    end
    en = 1'b1;
    chk(int'(i0) == p, "R8 stall position", int'(i0), p);
  endtask

  task automatic t_full_pass;
    int g;
    for (int p = 1; p < 64; p++) begin
      next_result(g);
      check_result(p, g, 6);
      if (p == 20) t_stall(20);
    end
  endtask

  task automatic t_wrap;
    int g;
    next_result(g);
    check_result(0, g, 6);
    chk(int'(avg_o) == ref_avg(0), "R7 fresh sum after wrap", int'(avg_o), ref_avg(0));
    next_result(g);
    check_result(1, g, 6);
  endtask

  task automatic t_midreset;
    int g;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(vld_o == 0 && idx_o == 0, "R1 mid-run reset", int'(idx_o), 0);
    rst = 1'b0;
    next_result(g);
    check_result(0, g, 6);
    chk(int'(avg_o) == ref_avg(0), "R7 no stale sum after reset", int'(avg_o), ref_avg(0));
  endtask

  initial begin
    t_reset();
    t_full_pass();
    t_wrap();
    t_midreset();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule